// File: doc/BRIEF.md
# Watch Timer with Infrared Carrier Capture

This block is a periodic interval timer for a low-speed timekeeping clock domain. A low counter of `LO_W` bits and a high counter of `HI_W` bits form one combined count. The low counter carries into the high counter when it wraps. Software programs a combined terminal value through a byte-wide register port. When the combined count reaches that value, an interrupt flag is raised and both counters restart from zero. The flag drives the interrupt output. It is cleared either by an acknowledge pulse from the interrupt controller or by a software write.

The period registers share their addresses with the live counters. A write sets the terminal value, and a read returns the current count, which lets software sample elapsed time directly. An infrared carrier input is brought in through a two-flop synchroniser. Its level is shown in the status register. In capture mode, the first carrier edge of the selected polarity latches the low count into a capture register. The capture register then holds that value until software clears and re-arms it.

The register bus is combinational on reads and takes effect on the clock edge for writes. It has no handshake.

Top module: `wtim_irc`

## Requirements
- R1: While mode bit 0 (run) is 1, the combined count advances by one on each clock edge. While run is 0, both counters are held at zero. A read of address 2 returns live low-count bits 7:0. A read of address 3 returns low-count bits LO_W-1:8, zero-extended. A read of address 4 returns the live high count, zero-extended.
- R2: After reset, both period values are all ones, the mode register and the interrupt flag are 0, and the capture value is all ones. With the period left at its reset value, the first interrupt comes 2^(LO_W+HI_W) cycles after run is set.
- R3: The period P is (high period × 2^LO_W) + low period. Writes to address 2 set low-period bits 7:0, writes to address 3 set low-period bits LO_W-1:8, and writes to address 4 set the high period. When the running count equals P, the next edge sets the flag and returns both counters to zero, so the flag sets every P+1 cycles. irq_o shows the flag.
- R4: When the low counter is all ones and the terminal count is not reached, the next edge wraps the low counter to zero and increments the high counter.
- R5: The flag clears on an edge where irq_ack_i is 1. It also clears on a write to address 0 with data bit 0 equal to 0. A write to address 0 with bit 0 equal to 1 leaves the flag unchanged.
- R6: When the terminal count falls on the same edge as an acknowledge or a clearing write, the flag ends up set.
- R7: A read of address 0 returns the synchronised carrier level in bit 7 and the flag in bit 0. Bits 6:1 read as zero. The carrier level appears two edges after the input changes.
- R8: With mode bit 1 (capture enable) set, mode bit 2 selects the capture edge: 0 selects falling and 1 selects rising. The captured value is the low count current two edges after the first edge that samples the new carrier level. A read of address 5 returns capture bits 7:0. A read of address 6 returns capture bits LO_W-1:8.
- R9: After a capture, further carrier edges are ignored until re-armed. A mode write with data bit 3 set makes the capture all ones and re-arms it. Bit 3 is not stored. With capture enable at 0, carrier edges are ignored.
- R10: Address 1 reads back mode bits 2:0, with bits 7:3 reading as zero. Address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write enable, takes effect at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| carrier_i | input | 1 | Asynchronous infrared carrier input |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request (the flag) |

## Verification
The bench builds the block with LO_W = 10 and HI_W = 3 instead of the default 14 and 7. This shrinks the reset-value period to 8192 cycles, so the first-interrupt timing under R2 and the low-to-high carry under R4 can both be observed on a short run. The upper capture and count bytes still contain real bits (9:8). This keeps the byte-split read path and the partial upper byte exercised. Small written periods then place the coincident-clear cases of R6 at exact, countable cycles.

// File: rtl/wtim_pkg.sv
// Shared definitions for the watch timer: register addresses and mode layout.
// Assumes a 3-bit byte address space.
package wtim_pkg;

    localparam int ADDR_W       = 3;
    localparam int MODE_CLR_BIT = 3;   // write-only re-arm strobe in the mode byte

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 3'd0,
        A_MODE  = 3'd1,
        A_CNT_L = 3'd2,
        A_CNT_M = 3'd3,
        A_CNT_H = 3'd4,
        A_CAP_L = 3'd5,
        A_CAP_M = 3'd6,
        A_NONE  = 3'd7
    } wt_addr_e;

    // Stored mode bits, MSB first: bit 2 rise_sel, bit 1 cap_en, bit 0 run
    typedef struct packed {
        logic rise_sel;
        logic cap_en;
        logic run;
    } mode_t;

endpackage

// File: rtl/wtim_count.sv
// Two-stage interval counter. The low stage wraps into the high stage, and
// both restart at zero on the terminal count. Assumes run is a registered
// control; when run is low the stages are forced to zero.
module wtim_count #(
    parameter int LO_W = 14,
    parameter int HI_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [LO_W-1:0] prd_lo,
    input  logic [HI_W-1:0] prd_hi,
    output logic [LO_W-1:0] cnt_lo,
    output logic [HI_W-1:0] cnt_hi,
    output logic            hit
);

    logic lo_full;

    // Terminal-count detect: both stages equal their programmed period
    always_comb begin
        hit     = run && (cnt_lo == prd_lo) && (cnt_hi == prd_hi);
        lo_full = &cnt_lo;
    end

    // Count, carry and restart
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (hit) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else begin
            cnt_lo <= cnt_lo + 1'b1;
            if (lo_full) begin
                cnt_hi <= cnt_hi + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wtim_capture.sv
// Carrier synchroniser, edge detector and one-shot capture register.
// Assumes carrier_i is asynchronous. Two flops resolve metastability and a
// third holds the previous level for edge detection.
module wtim_capture #(
    parameter int LO_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            carrier_i,
    input  logic            cap_en,
    input  logic            rise_sel,
    input  logic            cap_clr,
    input  logic [LO_W-1:0] cnt_lo,
    output logic            carrier_lvl,
    output logic [LO_W-1:0] cap,
    output logic            armed
);

    logic [2:0] sync_q;
    logic       prev_lvl;
    logic       edge_hit;

    // Synchroniser and history shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], carrier_i};
        end
    end

    // Pick the edge polarity selected by the mode register
    always_comb begin
        carrier_lvl = sync_q[1];
        prev_lvl    = sync_q[2];
        edge_hit    = rise_sel ? (carrier_lvl & ~prev_lvl)
                               : (~carrier_lvl & prev_lvl);
    end

    // Latch the low count once per arming; clear re-arms with priority
    always_ff @(posedge clk) begin
        if (!rst_n || cap_clr) begin
            cap   <= '1;
            armed <= 1'b1;
        end else if (cap_en && armed && edge_hit) begin
            cap   <= cnt_lo;
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/wtim_regs.sv
// Byte register port: holds the periods and the mode, decodes strobes and
// multiplexes read data. Assumes 8 < LO_W <= 16 and HI_W <= 8. Reads of the
// period addresses return the live counters.
module wtim_regs
    import wtim_pkg::*;
#(
    parameter int LO_W = 14,
    parameter int HI_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    input  logic [LO_W-1:0]   cnt_lo,
    input  logic [HI_W-1:0]   cnt_hi,
    input  logic [LO_W-1:0]   cap,
    input  logic              carrier_lvl,
    input  logic              flag,
    output logic [LO_W-1:0]   prd_lo,
    output logic [HI_W-1:0]   prd_hi,
    output mode_t             mode,
    output logic              cap_clr,
    output logic              stat_clr,
    output logic [7:0]        rdata
);

    localparam int MID_W = LO_W - 8;

    wt_addr_e sel;

    // Address decode and write strobes
    always_comb begin
        sel      = wt_addr_e'(addr);
        cap_clr  = we && (sel == A_MODE) && wdata[MODE_CLR_BIT];
        stat_clr = we && (sel == A_STAT) && !wdata[0];
    end

    // Period and mode storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_lo <= '1;
            prd_hi <= '1;
            mode   <= '0;
        end else if (we) begin
            case (sel)
                A_MODE:  mode              <= mode_t'(wdata[2:0]);
                A_CNT_L: prd_lo[7:0]       <= wdata;
                A_CNT_M: prd_lo[LO_W-1:8]  <= wdata[MID_W-1:0];
                A_CNT_H: prd_hi            <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer: status, mode, live counters, capture
    always_comb begin
        case (sel)
            A_STAT:  rdata = {carrier_lvl, 6'b0, flag};
            A_MODE:  rdata = {5'b0, mode};
            A_CNT_L: rdata = cnt_lo[7:0];
            A_CNT_M: rdata = 8'(cnt_lo[LO_W-1:8]);
            A_CNT_H: rdata = 8'(cnt_hi);
            A_CAP_L: rdata = cap[7:0];
            A_CAP_M: rdata = 8'(cap[LO_W-1:8]);
            default: rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/wtim_irc.sv
// Watch timer top: a two-stage interval counter with an interrupt flag,
// a byte register port, and one-shot capture of an infrared carrier edge.
// Assumes one clock and a synchronous active-low reset. A terminal count
// that coincides with a clear leaves the flag set.
module wtim_irc
    import wtim_pkg::*;
#(
    parameter int LO_W = 14,
    parameter int HI_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr_i,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       carrier_i,
    input  logic       irq_ack_i,
    output logic       irq_o
);

    logic [LO_W-1:0] prd_lo;
    logic [HI_W-1:0] prd_hi;
    logic [LO_W-1:0] cnt_lo;
    logic [HI_W-1:0] cnt_hi;
    logic [LO_W-1:0] cap;
    mode_t           mode;
    logic            run;
    logic            hit;
    logic            flag;
    logic            cap_clr;
    logic            stat_clr;
    logic            carrier_lvl;
    logic            armed;

    assign run   = mode.run;
    assign irq_o = flag;

    wtim_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr_i),
        .we          (we_i),
        .wdata       (wdata_i),
        .cnt_lo      (cnt_lo),
        .cnt_hi      (cnt_hi),
        .cap         (cap),
        .carrier_lvl (carrier_lvl),
        .flag        (flag),
        .prd_lo      (prd_lo),
        .prd_hi      (prd_hi),
        .mode        (mode),
        .cap_clr     (cap_clr),
        .stat_clr    (stat_clr),
        .rdata       (rdata_o)
    );

    wtim_count #(.LO_W(LO_W), .HI_W(HI_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .prd_lo (prd_lo),
        .prd_hi (prd_hi),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .hit    (hit)
    );

    wtim_capture #(.LO_W(LO_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .carrier_i   (carrier_i),
        .cap_en      (mode.cap_en),
        .rise_sel    (mode.rise_sel),
        .cap_clr     (cap_clr),
        .cnt_lo      (cnt_lo),
        .carrier_lvl (carrier_lvl),
        .cap         (cap),
        .armed       (armed)
    );

    // Interrupt flag: set on terminal count, which outranks both clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (irq_ack_i || stat_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wtim_chk.sv
// Property checker for the watch timer, attached by bind. It observes the
// ports and the signals passed between the submodules.
module wtim_chk #(
    parameter int LO_W = 14,
    parameter int HI_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      addr_i,
    input logic [7:0]      rdata_o,
    input logic            irq_ack_i,
    input logic            irq_o,
    input logic            run,
    input logic            hit,
    input logic            stat_clr,
    input logic            cap_clr,
    input logic            armed,
    input logic [LO_W-1:0] cnt_lo,
    input logic [HI_W-1:0] cnt_hi,
    input logic [LO_W-1:0] cap
);

    // R1: stopped timer holds zero
    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_lo == '0 && cnt_hi == '0));

    // R1: running timer steps the low stage by one
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hit && !(&cnt_lo)) |=> (cnt_lo == LO_W'($past(cnt_lo) + 1'b1)));

    // R3: terminal count raises the flag and restarts both stages
    assert_terminal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (irq_o && cnt_lo == '0 && cnt_hi == '0));

    // R4: low wrap carries into the high stage
    assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !hit && (&cnt_lo)) |=>
        (cnt_lo == '0 && cnt_hi == HI_W'($past(cnt_hi) + 1'b1)));

    // R5: acknowledge without a terminal count drops the request
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !hit) |=> !irq_o);

    // R6: setting outranks a coincident clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (irq_ack_i || stat_clr)) |=> irq_o);

    // R7: unused status bits read as zero
    assert_stat_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 3'd0) |-> (rdata_o[6:1] == 6'd0));

    // R9: disarmed capture register is frozen
    assert_cap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !cap_clr) |=> $stable(cap));

    // R10: unmapped address reads zero
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 3'd7) |-> (rdata_o == 8'h00));

endmodule

bind wtim_irc wtim_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .irq_ack_i (irq_ack_i),
    .irq_o     (irq_o),
    .run       (run),
    .hit       (hit),
    .stat_clr  (stat_clr),
    .cap_clr   (cap_clr),
    .armed     (armed),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .cap       (cap)
);

// File: tb/test_wtim_irc.sv
// Scoreboard bench: driver tasks queue expected read data and interrupt
// levels at known cycles, and a monitor pops and compares them.
module test_wtim_irc;

    localparam int LO_W = 10;
    localparam int HI_W = 3;
    localparam logic [2:0] STAT = 3'd0, MODE = 3'd1, CNTL = 3'd2, CNTM = 3'd3,
                           CNTH = 3'd4, CAPL = 3'd5, CAPM = 3'd6, NONE = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr_i = '0;
    logic       we_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       carrier_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic       irq_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int wr_edge = 0;
    bit done = 1'b0;

    int    rd_cyc_q[$];
    int    rd_exp_q[$];
    string rd_tag_q[$];
    int    iq_cyc_q[$];
    int    iq_exp_q[$];
    string iq_tag_q[$];

    wtim_irc #(.LO_W(LO_W), .HI_W(HI_W)) i_wtim_irc (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .we_i      (we_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .carrier_i (carrier_i),
        .irq_ack_i (irq_ack_i),
        .irq_o     (irq_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        #2;
        while (rd_cyc_q.size() > 0 && rd_cyc_q[0] <= cyc) begin
            checks++;
            if (rd_cyc_q[0] != cyc || rdata_o !== 8'(rd_exp_q[0])) begin
                fails++;
                $display("FAIL %s: cycle %0d read actual=%02h expected=%02h",
                         rd_tag_q[0], cyc, rdata_o, rd_exp_q[0]);
            end
            void'(rd_cyc_q.pop_front());
            void'(rd_exp_q.pop_front());
            void'(rd_tag_q.pop_front());
        end
        while (iq_cyc_q.size() > 0 && iq_cyc_q[0] <= cyc) begin
            checks++;
            if (iq_cyc_q[0] != cyc || irq_o !== 1'(iq_exp_q[0])) begin
                fails++;
                $display("FAIL %s: cycle %0d irq actual=%0b expected=%0d",
                         iq_tag_q[0], cyc, irq_o, iq_exp_q[0]);
            end
            void'(iq_cyc_q.pop_front());
            void'(iq_exp_q.pop_front());
            void'(iq_tag_q.pop_front());
        end
    end

    task automatic wait_until(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        addr_i  = a;
        wdata_i = d;
        we_i    = 1'b1;
        wr_edge = cyc + 1;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input int exp, input string tag);
        addr_i = a;
        rd_cyc_q.push_back(cyc);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic expect_irq(input int c, input int v, input string tag);
        iq_cyc_q.push_back(c);
        iq_exp_q.push_back(v);
        iq_tag_q.push_back(tag);
    endtask

    task automatic pulse_ack();
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            finish_run();
        end
    end

    // Driver
    initial begin
        int w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state, R10 unmapped read
        bus_rd(STAT, 8'h00, "R2");
        bus_rd(MODE, 8'h00, "R2");
        bus_rd(CNTL, 8'h00, "R2");
        bus_rd(CAPL, 8'hFF, "R2");
        bus_rd(CAPM, 8'h03, "R2");
        bus_rd(NONE, 8'h00, "R10");

        // R2 default period, R1 live count, R4 carry
        bus_wr(MODE, 8'h01);
        w = wr_edge;
        expect_irq(w + 8191, 0, "R2");
        expect_irq(w + 8192, 1, "R2");
        expect_irq(w + 8194, 0, "R5");
        wait_until(w + 600);
        bus_rd(CNTL, 8'h58, "R1");
        bus_rd(CNTM, 8'h02, "R1");
        wait_until(w + 1025);
        bus_rd(CNTH, 8'h01, "R4");
        bus_rd(CNTL, 8'h02, "R4");
        bus_rd(CNTM, 8'h00, "R4");
        wait_until(w + 8193);
        bus_wr(STAT, 8'h00);
        bus_wr(MODE, 8'h00);
        wait_until(wr_edge + 2);
        bus_rd(CNTL, 8'h00, "R1");
        bus_rd(CNTH, 8'h00, "R1");

        // R3 short period, R5 clears, R6 priority
        bus_wr(CNTL, 8'h05);
        bus_wr(CNTM, 8'h00);
        bus_wr(CNTH, 8'h00);
        bus_wr(MODE, 8'h01);
        w = wr_edge;
        expect_irq(w + 5,  0, "R3");
        expect_irq(w + 6,  1, "R3");
        expect_irq(w + 8,  0, "R5");
        expect_irq(w + 12, 1, "R3");
        expect_irq(w + 18, 1, "R6");
        expect_irq(w + 24, 1, "R6");
        expect_irq(w + 26, 0, "R5");
        expect_irq(w + 28, 0, "R5");
        expect_irq(w + 30, 1, "R3");
        wait_until(w + 7);
        pulse_ack();
        wait_until(w + 17);
        bus_wr(STAT, 8'h00);
        wait_until(w + 23);
        pulse_ack();
        wait_until(w + 25);
        bus_wr(STAT, 8'h00);
        wait_until(w + 27);
        bus_wr(STAT, 8'h01);
        wait_until(w + 31);
        bus_rd(CNTL, 8'h01, "R3");
        bus_wr(MODE, 8'h00);

        // R4 period that spans the high stage
        bus_wr(CNTL, 8'h03);
        bus_wr(CNTM, 8'h00);
        bus_wr(CNTH, 8'h01);
        bus_wr(STAT, 8'h00);
        bus_wr(MODE, 8'h01);
        w = wr_edge;
        expect_irq(w + 1027, 0, "R4");
        expect_irq(w + 1028, 1, "R4");
        wait_until(w + 1029);
        bus_wr(STAT, 8'h00);
        bus_wr(MODE, 8'h00);

        // R7/R8 falling-edge capture
        bus_wr(CNTL, 8'hFF);
        bus_wr(CNTM, 8'h03);
        bus_wr(CNTH, 8'h07);
        bus_wr(MODE, 8'h03);
        w = wr_edge;
        wait_until(w + 50);
        carrier_i = 1'b1;
        wait_until(w + 54);
        bus_rd(STAT, 8'h80, "R7");
        bus_rd(CAPL, 8'hFF, "R8");
        bus_rd(CAPM, 8'h03, "R8");
        wait_until(w + 100);
        carrier_i = 1'b0;
        wait_until(w + 110);
        bus_rd(CAPL, 8'h66, "R8");
        bus_rd(CAPM, 8'h00, "R8");
        bus_rd(STAT, 8'h00, "R7");
        // R9 second pulse ignored
        wait_until(w + 120);
        carrier_i = 1'b1;
        wait_until(w + 140);
        carrier_i = 1'b0;
        wait_until(w + 150);
        bus_rd(CAPL, 8'h66, "R9");

        // R9 re-arm, R8 rising polarity, R10 mode readback
        wait_until(w + 160);
        bus_wr(MODE, 8'h0F);
        wait_until(w + 162);
        bus_rd(CAPL, 8'hFF, "R9");
        bus_rd(CAPM, 8'h03, "R9");
        bus_rd(MODE, 8'h07, "R10");
        wait_until(w + 200);
        carrier_i = 1'b1;
        wait_until(w + 210);
        bus_rd(CAPL, 8'hCA, "R8");
        bus_rd(CAPM, 8'h00, "R8");

        // R9 capture disabled ignores edges
        wait_until(w + 220);
        bus_wr(MODE, 8'h09);
        wait_until(w + 240);
        carrier_i = 1'b0;
        wait_until(w + 260);
        carrier_i = 1'b1;
        wait_until(w + 270);
        bus_rd(CAPL, 8'hFF, "R9");
        bus_rd(CAPM, 8'h03, "R9");
        bus_wr(MODE, 8'h00);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule